// File: doc/BRIEF.md
# Flash Program/Erase Status Read Generator

This block sits on the read path of a flash controller. While an embedded program or erase operation runs, reads must not return array contents. Instead they return a status byte, so that software can tell when the operation has finished. The status byte carries two completion indicators that work independently of each other.

The top data bit gives a polling value. During a byte program, a read of the address that was last loaded returns the inverse of the top bit of the loaded byte. The bit below it is a toggle flag. It changes on every read access for as long as the operation lasts.

Each read access is marked by a one-cycle strobe. The byte built for that access is registered on the strobe and held on the output until the next strobe. Once busy falls, reads return the array data unchanged and the toggle flag stops moving.

Top module: `flash_status_rdgen`

## Requirements
- R1: After reset, `rd_data` is all zeros until the first read strobe.
- R2: With busy high and `op_kind` = 2'b01 (byte program), a read whose address equals `last_addr` returns, on bit 7, the inverse of bit 7 of `last_data`.
- R3: With busy high and `op_kind` = 2'b01, a read of any other address returns 0 on bit 7.
- R4: With busy high and `op_kind` = 2'b10 (chip erase), or any code other than 2'b01, bit 7 of every read is 0.
- R5: While busy is high, bit 6 of each read differs from bit 6 of the previous read in the same busy period.
- R6: While busy is high, bits 5..0 of every read are 0.
- R7: With busy low, a read returns exactly the `array_data` present in the strobe cycle.
- R8: The toggle flag advances once per strobe and never on strobe-free cycles, whatever the gap between strobes. `rd_data` holds its value between strobes even if the inputs change.
- R9: The first read after busy rises already returns the status byte, not array data.
- R10: Once busy falls, the next read returns true array data on all bits, including bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Internal program or erase in progress |
| op_kind | input | 2 | Operation in progress: 2'b01 byte program, 2'b10 chip erase |
| last_addr | input | ADDR_W | Address of the last loaded program byte |
| last_data | input | DATA_W | Last loaded program byte |
| rd_addr | input | ADDR_W | Address of the current read |
| rd_strobe | input | 1 | One-cycle pulse per read access |
| array_data | input | DATA_W | Data read from the array at `rd_addr` |
| rd_data | output | DATA_W | Byte returned to the bus, updated one cycle after a strobe |

## Verification
Reads are issued with the strobes back to back and with gaps of several cycles. Equal alternation in both cases shows the toggle follows strobes, not clocks. Program reads use loaded bytes whose top bit is 0 and then 1, at the matched address and at a different one. This separates inversion from a constant value and separates the address match from the operation type. Erase reads, idle reads of array bytes with bit 6 set, and the first read after each busy edge show whether status is substituted only during the busy window.

// File: rtl/flash_status_rdgen_pkg.sv
package flash_status_rdgen_pkg;

  typedef enum logic [1:0] {
    OPK_NONE  = 2'b00,
    OPK_PROG  = 2'b01,
    OPK_ERASE = 2'b10,
    OPK_RSVD  = 2'b11
  } opk_e;

  // Polling bit value while busy: inverse of the loaded top bit only for a
  // byte program read at the loaded address, zero otherwise.
  function automatic logic poll_value(input opk_e op, input logic addr_hit,
                                      input logic loaded_top);
    return (op == OPK_PROG && addr_hit) ? ~loaded_top : 1'b0;
  endfunction

  // Next state of the toggle flag for one clock.
  function automatic logic toggle_next(input logic cur, input logic advance);
    return advance ? ~cur : cur;
  endfunction

endpackage

// File: rtl/rsg_addr_match.sv
module rsg_addr_match #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic              hit
);
  logic [ADDR_W-1:0] diff;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign diff[i] = addr_a[i] ^ addr_b[i];
  end

  assign hit = ~|diff;
endmodule

// File: rtl/rsg_toggle.sv
module rsg_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic tgl_q
);
  import flash_status_rdgen_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= toggle_next(tgl_q, advance);
  end
endmodule

// File: rtl/rsg_status_mux.sv
module rsg_status_mux #(
  parameter int DATA_W = 8
) (
  input  logic              busy,
  input  logic [1:0]        op_kind,
  input  logic              addr_hit,
  input  logic              loaded_top,
  input  logic              tgl_q,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] byte_out
);
  import flash_status_rdgen_pkg::*;

  localparam int POLL_BIT = DATA_W - 1;
  localparam int TGL_BIT  = DATA_W - 2;

  logic poll_v;
  assign poll_v = poll_value(opk_e'(op_kind), addr_hit, loaded_top);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign byte_out[i] = busy ? poll_v : array_data[i];
    end else if (i == TGL_BIT) begin : g_tgl
      assign byte_out[i] = busy ? tgl_q : array_data[i];
    end else begin : g_zero
      assign byte_out[i] = busy ? 1'b0 : array_data[i];
    end
  end
endmodule

// File: rtl/flash_status_rdgen.sv
module flash_status_rdgen #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [DATA_W-1:0] last_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int POLL_BIT = DATA_W - 1;

  // Named internal events for the checker.
  logic              addr_hit;
  logic              tgl_adv;
  logic              tgl_q;
  logic [DATA_W-1:0] formed;

  assign tgl_adv = rd_strobe & busy;

  rsg_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .addr_a (rd_addr),
    .addr_b (last_addr),
    .hit    (addr_hit)
  );

  rsg_toggle u_tgl (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (tgl_adv),
    .tgl_q   (tgl_q)
  );

  rsg_status_mux #(.DATA_W(DATA_W)) u_mux (
    .busy       (busy),
    .op_kind    (op_kind),
    .addr_hit   (addr_hit),
    .loaded_top (last_data[POLL_BIT]),
    .tgl_q      (tgl_q),
    .array_data (array_data),
    .byte_out   (formed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_data <= '0;
    else if (rd_strobe) rd_data <= formed;
  end
endmodule

// File: rtl/flash_status_rdgen_chk.sv
module flash_status_rdgen_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [1:0]        op_kind,
  input logic [ADDR_W-1:0] last_addr,
  input logic [DATA_W-1:0] last_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_strobe,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              tgl_q
);
  localparam int PB = DATA_W - 1;

  a_r2_prog_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && busy && op_kind == 2'b01 && rd_addr == last_addr)
      |=> rd_data[PB] == !$past(last_data[PB]));

  a_r3_prog_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && busy && op_kind == 2'b01 && rd_addr != last_addr)
      |=> !rd_data[PB]);

  a_r4_erase_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && busy && op_kind != 2'b01) |=> !rd_data[PB]);

  a_r5_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && busy) |=> tgl_q != $past(tgl_q));

  a_r6_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && busy) |=> rd_data[DATA_W-3:0] == '0);

  a_r7_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !busy) |=> rd_data == $past(array_data));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(rd_data) && $stable(tgl_q));

  a_r10_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(tgl_q));
endmodule

bind flash_status_rdgen flash_status_rdgen_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .op_kind    (op_kind),
  .last_addr  (last_addr),
  .last_data  (last_data),
  .rd_addr    (rd_addr),
  .rd_strobe  (rd_strobe),
  .array_data (array_data),
  .rd_data    (rd_data),
  .tgl_q      (tgl_q)
);

// File: tb/flash_status_rdgen_bench.sv
module flash_status_rdgen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;

  typedef struct {
    logic [DW-1:0] exp;
    logic [DW-1:0] mask;
    logic          bsy;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          busy = 1'b0;
  logic [1:0]    op_kind = 2'b00;
  logic [AW-1:0] last_addr = '0;
  logic [DW-1:0] last_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_strobe = 1'b0;
  logic [DW-1:0] array_data = '0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  item_t sb[$];
  logic  prev_tgl;
  logic  prev_ok = 1'b0;
  logic  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_rdgen #(.ADDR_W(AW), .DATA_W(DW)) u_flash_status_rdgen (
    .clk(clk), .rst_n(rst_n), .busy(busy), .op_kind(op_kind),
    .last_addr(last_addr), .last_data(last_data), .rd_addr(rd_addr),
    .rd_strobe(rd_strobe), .array_data(array_data), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] predict(input logic b, input logic [1:0] op,
      input logic [AW-1:0] a, input logic [AW-1:0] la,
      input logic [DW-1:0] ld, input logic [DW-1:0] arr);
    logic [DW-1:0] e;
    if (!b) return arr;
    e = '0;
    if (op == 2'b01 && a == la) e[7] = ~ld[7];
    return e;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string tag, input int gap);
    item_t it;
    rd_addr = a;
    it.exp  = predict(busy, op_kind, a, last_addr, last_data, array_data);
    it.mask = busy ? 8'hBF : 8'hFF;
    it.bsy  = busy;
    it.tag  = tag;
    sb.push_back(it);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // Monitor: compare each registered result one cycle after its strobe.
  initial begin
    forever begin
      @(posedge clk);
      if (rd_strobe && rst_n) begin
        item_t it;
        @(negedge clk);
        it = sb.pop_front();
        check(it.tag, rd_data & it.mask, it.exp & it.mask);
        if (it.bsy) begin
          if (prev_ok) check({it.tag, " R5 toggle"}, {7'd0, rd_data[6]}, {7'd0, ~prev_tgl});
          prev_tgl = rd_data[6];
          prev_ok  = 1'b1;
        end else begin
          prev_ok = 1'b0;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset value", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", rd_data, 8'h00);

    // R7 idle pass-through, including bit 6 set
    array_data = 8'h6C; do_read(16'h0100, "R7 idle a", 0);
    array_data = 8'hC5; do_read(16'h0101, "R7 idle b", 2);

    // R2 / R9 / R5 / R6 program, loaded top bit 0
    last_addr = 16'h1234; last_data = 8'h5A; op_kind = 2'b01; busy = 1'b1;
    array_data = 8'hFF;
    do_read(16'h1234, "R9 R2 first read", 0);
    do_read(16'h1234, "R2 R6 back-to-back", 0);
    do_read(16'h1234, "R2 R8 gap", 4);
    do_read(16'h4321, "R3 other address", 1);
    // loaded top bit 1
    last_data = 8'hC3;
    do_read(16'h1234, "R2 top one", 3);
    do_read(16'h1234, "R2 R5 again", 0);

    // R10 completion: true data incl. bit 6
    busy = 1'b0; array_data = 8'h43;
    do_read(16'h1234, "R10 done", 1);
    array_data = 8'h40;
    do_read(16'h1234, "R10 steady", 1);

    // R4 erase
    op_kind = 2'b10; busy = 1'b1; array_data = 8'hFF; last_addr = 16'h0007; last_data = 8'h00;
    do_read(16'h0007, "R4 R9 erase first", 0);
    do_read(16'h0007, "R4 erase", 5);
    do_read(16'h2000, "R4 R6 erase", 0);
    do_read(16'h2000, "R4 R5 erase", 2);

    // R8 hold between strobes while inputs move
    @(negedge clk);
    held = rd_data;
    array_data = 8'h11; rd_addr = 16'h0007; busy = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 hold without strobe", rd_data, held);
    array_data = 8'h99;
    do_read(16'h0003, "R7 after hold", 2);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule